// File: doc/BRIEF.md
# Decimal-Mode 8-Bit Add/Subtract Unit

This block is the arithmetic core of an 8-bit accumulator processor. It performs add-with-carry and subtract-with-borrow on an accumulator value and an operand. It works either in plain binary or in packed BCD, where each nibble holds one decimal digit. In decimal mode the flags follow the quirks of the early NMOS processors. They do not describe the decimal result. Zero on an add comes from the binary sum. Negative and overflow on an add come from an intermediate value taken before the high-digit correction. All subtract flags come from the plain binary difference.

An operation starts with a one-cycle start strobe, which carries an add/subtract select. The result, the four arithmetic flags and a one-cycle done pulse are registered on the next clock edge. They then hold until the next strobe.

The block also presents an 8-bit status image. This image has a defined reset value, and it packs the flags, the decimal mode of the last operation and two constant bits.

Top module: `bcd_alu_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the result is 0x00, all four flags are 0, done is 0 and the status image is 0x24.
- R2: A start strobe sampled at a rising edge makes the result, flags and done change at that edge. Done is high for exactly one cycle. Without a strobe, the result and flags keep their values.
- R3: For a binary add (sub_i=0, dec_i=0), the result is the low byte of A+M+Cin, and carry is set when that sum exceeds 255.
- R4: For a binary add, negative is bit 7 of the sum and zero means the low byte of the sum is 0. Overflow is set when A and M agree in bit 7 and the sum's bit 7 differs from A's.
- R5: For a decimal add, the low digit t=A[3:0]+M[3:0]+Cin is increased by 6 when it is above 9. The intermediate is (t&0xF)+(A&0xF0)+(M&0xF0), plus 0x10 when the corrected t exceeds 0x0F. Then 0x60 is added when the intermediate exceeds 0x90. Carry is set when the final value exceeds 0xF0, and the result is its low byte.
- R6: For a decimal add, zero reflects the low byte of the binary sum A+M+Cin, not the decimal result.
- R7: For a decimal add, negative is bit 7 of the intermediate before the 0x60 correction. Overflow is set when A and M agree in bit 7 and the intermediate's bit 7 differs from A's.
- R8: For a subtract in either mode, d=A-M-(1-Cin) is formed in wide arithmetic. Carry is set when no borrow occurs (d<0x100). Zero and negative come from the low byte of d. In binary mode the result is the low byte of d.
- R9: For a subtract in either mode, overflow is set when A and M differ in bit 7 and bit 7 of d differs from A's.
- R10: For a decimal subtract, the low digit is u=A[3:0]-M[3:0]-(1-Cin). If u bit 4 is set, the value is (((u-6)&0xF)|(A&0xF0))-(M&0xF0)-0x10. Otherwise it is ((u&0xF)|(A&0xF0))-(M&0xF0). A further 0x60 is subtracted when bit 8 of the value is set, and the result is the low byte.
- R11: The status image holds, from bit 7 down: negative, overflow, constant 1, constant 0, decimal mode of the last operation, constant 1 (interrupts disabled), zero, carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle launch strobe |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| dec_i | input | 1 | 1 selects packed-BCD mode |
| carry_i | input | 1 | Carry in (for a subtract, 1 means no borrow) |
| acc_i | input | 8 | Accumulator operand A |
| opr_i | input | 8 | Second operand M |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Overflow flag |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Packed status image |

## Verification
The bench targets the decimal-mode flag quirks, because each one gives a wrong result that is easy to see.

- 0x99+0x01 in decimal mode yields 0x00 with carry set but zero clear, and with negative set. A design that took zero or negative from the corrected result would report zero set and negative clear.
- 0x58+0x46+1 raises overflow from the uncorrected intermediate. A design that evaluated overflow after the correction, or never set it in decimal mode, would miss this.
- The subtract cases include 0x00-0x01, which must wrap to 0x99 with borrow. A missing 0x60 correction would give 0xF9.
- A low-digit borrow case (0x40-0x13) shows whether the extra 0x10 borrow is carried into the high digit.
- Binary overflow edges (0x7F+1, 0x80-1) and a reset applied in the middle of a run check the rest.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int DW  = 8;          // data byte width
    localparam int NW  = DW / 2;     // one BCD digit
    localparam int WW  = 2 * DW;     // wide arithmetic width for subtract
    localparam int AW  = DW + 2;     // add intermediate width incl. headroom

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        flags_t        fl;
        logic          dec;
        logic          done;
    } state_t;

endpackage

// File: rtl/bcd_adder_path.sv
module bcd_adder_path
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    input  logic          dec,
    output logic [DW-1:0] res,
    output flags_t        fl
);

    logic [DW:0]   bsum;
    logic [NW+1:0] lo;
    logic [AW-1:0] mid;
    logic [AW-1:0] fin;

    always_comb begin
        bsum = {1'b0, a} + {1'b0, m} + (DW+1)'(cin);

        // decimal path: low digit correction, then high digit
        lo = (NW+2)'(a[NW-1:0]) + (NW+2)'(m[NW-1:0]) + (NW+2)'(cin);
        if (lo > (NW+2)'(9))
            lo = lo + (NW+2)'(6);
        mid = AW'(lo[NW-1:0]) + AW'({a[DW-1:NW], {NW{1'b0}}})
            + AW'({m[DW-1:NW], {NW{1'b0}}});
        if (lo > (NW+2)'(15))
            mid = mid + AW'(16);
        fin = (mid > AW'(8'h90)) ? mid + AW'(8'h60) : mid;

        if (dec) begin
            res  = fin[DW-1:0];
            fl.c = fin > AW'(8'hF0);
            fl.z = (bsum[DW-1:0] == '0);
            fl.n = mid[DW-1];
            fl.v = (a[DW-1] ^ mid[DW-1]) & ~(a[DW-1] ^ m[DW-1]);
        end else begin
            res  = bsum[DW-1:0];
            fl.c = bsum[DW];
            fl.z = (bsum[DW-1:0] == '0);
            fl.n = bsum[DW-1];
            fl.v = ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ bsum[DW-1]);
        end
    end

endmodule

// File: rtl/bcd_subtractor_path.sv
module bcd_subtractor_path
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    input  logic          dec,
    output logic [DW-1:0] res,
    output flags_t        fl
);

    logic [WW-1:0] diff;
    logic [WW-1:0] u;
    logic [WW-1:0] val;
    logic [WW-1:0] a_hi;
    logic [WW-1:0] m_hi;

    always_comb begin
        diff = WW'(a) - WW'(m) - WW'(!cin);
        a_hi = WW'({a[DW-1:NW], {NW{1'b0}}});
        m_hi = WW'({m[DW-1:NW], {NW{1'b0}}});

        u = WW'(a[NW-1:0]) - WW'(m[NW-1:0]) - WW'(!cin);
        if (u[NW])
            val = (((u - WW'(6)) & WW'(4'hF)) | a_hi) - m_hi - WW'(16);
        else
            val = ((u & WW'(4'hF)) | a_hi) - m_hi;
        if (val[DW])
            val = val - WW'(8'h60);

        res  = dec ? val[DW-1:0] : diff[DW-1:0];
        fl.c = (diff < WW'(1 << DW));
        fl.z = (diff[DW-1:0] == '0);
        fl.n = diff[DW-1];
        fl.v = (a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ diff[DW-1]);
    end

endmodule

// File: rtl/bcd_alu_unit.sv
module bcd_alu_unit
    import bcd_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          sub_i,
    input  logic          dec_i,
    input  logic          carry_i,
    input  logic [7:0]    acc_i,
    input  logic [7:0]    opr_i,
    output logic [7:0]    result_o,
    output logic          carry_o,
    output logic          zero_o,
    output logic          neg_o,
    output logic          ovf_o,
    output logic          done_o,
    output logic [7:0]    status_o
);

    logic [DW-1:0] add_res;
    logic [DW-1:0] sub_res;
    flags_t        add_fl;
    flags_t        sub_fl;
    state_t        st_d;
    state_t        st_q;

    bcd_adder_path u_add (
        .a   (acc_i),
        .m   (opr_i),
        .cin (carry_i),
        .dec (dec_i),
        .res (add_res),
        .fl  (add_fl)
    );

    bcd_subtractor_path u_sub (
        .a   (acc_i),
        .m   (opr_i),
        .cin (carry_i),
        .dec (dec_i),
        .res (sub_res),
        .fl  (sub_fl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.res  = sub_i ? sub_res : add_res;
            st_d.fl   = sub_i ? sub_fl  : add_fl;
            st_d.dec  = dec_i;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign carry_o  = st_q.fl.c;
    assign zero_o   = st_q.fl.z;
    assign neg_o    = st_q.fl.n;
    assign ovf_o    = st_q.fl.v;
    assign done_o   = st_q.done;
    assign status_o = {st_q.fl.n, st_q.fl.v, 1'b1, 1'b0,
                       st_q.dec, 1'b1, st_q.fl.z, st_q.fl.c};

endmodule

// File: rtl/bcd_alu_unit_chk.sv
module bcd_alu_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       sub_i,
    input logic       dec_i,
    input logic       carry_i,
    input logic [7:0] acc_i,
    input logic [7:0] opr_i,
    input logic [7:0] result_o,
    input logic       carry_o,
    input logic       zero_o,
    input logic       neg_o,
    input logic       ovf_o,
    input logic       done_o,
    input logic [7:0] status_o
);

    logic       armed;
    logic [8:0] ref_sum;
    logic [8:0] ref_diff;
    logic       ref_nob;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign ref_sum  = {1'b0, acc_i} + {1'b0, opr_i} + {8'd0, carry_i};
    assign ref_diff = {1'b0, acc_i} - {1'b0, opr_i} - {8'd0, !carry_i};
    assign ref_nob  = ({1'b0, acc_i} >= ({1'b0, opr_i} + {8'd0, !carry_i}));

    // R2
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && done_o) |-> $past(start_i));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !start_i) |=> $stable(result_o) && $stable(carry_o));

    // R11
    status_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[5] && status_o[2] && !status_o[4]);

    // R3
    bin_add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !sub_i && !dec_i) |=> carry_o == $past(ref_sum[8]));

    // R6
    dec_add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !sub_i && dec_i) |=> zero_o == ($past(ref_sum[7:0]) == 8'h00));

    // R8
    sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sub_i) |=> carry_o == $past(ref_nob));

    // R8
    bin_sub_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sub_i && !dec_i) |=> result_o == $past(ref_diff[7:0]));

endmodule

bind bcd_alu_unit bcd_alu_unit_chk u_chk (.*);

// File: tb/bcd_alu_unit_test.sv
module bcd_alu_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       sub_i = 1'b0;
    logic       dec_i = 1'b0;
    logic       carry_i = 1'b0;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] opr_i = 8'h00;
    logic [7:0] result_o;
    logic       carry_o, zero_o, neg_o, ovf_o, done_o;
    logic [7:0] status_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bcd_alu_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
        .dec_i(dec_i), .carry_i(carry_i), .acc_i(acc_i), .opr_i(opr_i),
        .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o),
        .neg_o(neg_o), .ovf_o(ovf_o), .done_o(done_o), .status_o(status_o)
    );

    // {sub, dec, cin, A, M, result, C Z N V}
    localparam int NV = 18;
    localparam logic [30:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,8'h01,8'h01,8'h02,4'b0000},
        {1'b0,1'b0,1'b0,8'hFF,8'h01,8'h00,4'b1100},
        {1'b0,1'b0,1'b0,8'h7F,8'h01,8'h80,4'b0011},
        {1'b0,1'b0,1'b1,8'h80,8'h80,8'h01,4'b1001},
        {1'b0,1'b1,1'b0,8'h09,8'h01,8'h10,4'b0000},
        {1'b0,1'b1,1'b0,8'h99,8'h01,8'h00,4'b1010},
        {1'b0,1'b1,1'b1,8'h58,8'h46,8'h05,4'b1011},
        {1'b0,1'b1,1'b0,8'h9C,8'h9D,8'h9F,4'b1001},
        {1'b0,1'b1,1'b0,8'h00,8'h00,8'h00,4'b0100},
        {1'b1,1'b0,1'b1,8'h05,8'h03,8'h02,4'b1000},
        {1'b1,1'b0,1'b1,8'h00,8'h01,8'hFF,4'b0010},
        {1'b1,1'b0,1'b1,8'h80,8'h01,8'h7F,4'b1001},
        {1'b1,1'b0,1'b1,8'h10,8'h10,8'h00,4'b1100},
        {1'b1,1'b1,1'b1,8'h46,8'h12,8'h34,4'b1000},
        {1'b1,1'b1,1'b1,8'h40,8'h13,8'h27,4'b1000},
        {1'b1,1'b1,1'b1,8'h00,8'h01,8'h99,4'b0010},
        {1'b1,1'b1,1'b0,8'h32,8'h02,8'h29,4'b1000},
        {1'b1,1'b1,1'b1,8'h00,8'h00,8'h00,4'b1100}
    };

    function automatic string req_res(input logic s, input logic d);
        if (!s && !d) return "R3";
        if (!s)       return "R5";
        if (!d)       return "R8";
        return "R10";
    endfunction

    function automatic string req_fl(input logic s, input logic d);
        if (!s && !d) return "R4";
        if (!s)       return "R6/R7";
        return "R8/R9";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, capture at the rising edge, sample at the next falling edge
    task automatic run_op(input logic s, input logic d, input logic c,
                          input logic [7:0] a, input logic [7:0] m);
        @(negedge clk);
        start_i = 1'b1; sub_i = s; dec_i = d; carry_i = c; acc_i = a; opr_i = m;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 status in reset", status_o, 8'h24);
        check("R1 result in reset", {result_o, carry_o, zero_o, neg_o, ovf_o, done_o}, 14'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after reset", status_o, 8'h24);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][30], VEC[i][29], VEC[i][28], VEC[i][27:20], VEC[i][19:12]);
            check(req_res(VEC[i][30], VEC[i][29]), result_o, VEC[i][11:4]);
            check(req_fl(VEC[i][30], VEC[i][29]), {carry_o, zero_o, neg_o, ovf_o}, VEC[i][3:0]);
            check("R2 done", done_o, 1'b1);
        end

        // R11: decimal add 0x99+0x01 -> C1 Z0 N1 V0, D1 -> 0xAD
        run_op(1'b0, 1'b1, 1'b0, 8'h99, 8'h01);
        check("R11 status dec add", status_o, 8'hAD);
        // R2: done drops, values hold while inputs move without a strobe
        acc_i = 8'h55; opr_i = 8'h22; sub_i = 1'b1; dec_i = 1'b0;
        @(negedge clk);
        check("R2 done one cycle", done_o, 1'b0);
        repeat (3) @(negedge clk);
        check("R2 hold result", result_o, 8'h00);
        check("R2 hold flags", {carry_o, zero_o, neg_o, ovf_o}, 4'b1010);

        // R11: binary sub 0x00-0x01 -> C0 Z0 N1 V0, D0 -> 0xA4
        run_op(1'b1, 1'b0, 1'b1, 8'h00, 8'h01);
        check("R11 status bin sub", status_o, 8'hA4);

        // back-to-back strobes: both complete, done stays high
        @(negedge clk);
        start_i = 1'b1; sub_i = 1'b0; dec_i = 1'b0; carry_i = 1'b0; acc_i = 8'h10; opr_i = 8'h20;
        @(negedge clk);
        check("R3 back-to-back first", result_o, 8'h30);
        acc_i = 8'h40; opr_i = 8'h02;
        @(negedge clk);
        start_i = 1'b0;
        check("R3 back-to-back second", result_o, 8'h42);
        check("R2 done back-to-back", done_o, 1'b1);

        // R1: reset in the middle of a run
        run_op(1'b0, 1'b1, 1'b1, 8'h58, 8'h46);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset status", status_o, 8'h24);
        check("R1 mid-run reset result", {result_o, done_o}, 9'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule